// File: doc/BRIEF.md
# Write-Leveling Phase Sweep Engine

This block steps the transmit strobe (DQS) phase of every byte lane through a fixed window during DRAM write leveling. At each step it asks the PHY for a reset pulse, waits a settling time measured in timer strobes, and samples one feedback count per lane. A lane passes at that step when its count is high enough. Each lane keeps the longest unbroken run of passing steps. A run that reaches the last step is joined to a run that began at the first step, so a passing region may wrap around the end of the sweep.

After the sweep, the lanes are finished one by one. The width of each region is checked against a window. For x16 devices, an odd lane's region start is pulled to within half a clock of its even partner. An optional quarter-clock can be added to every DQS delay. The DQ delay is then set a fixed distance after the DQS delay. A `done` pulse ends the run, and all results stay fixed until the next start.

Top module: `wl_phase_sweep`

## Requirements
- R1: After a start, each lane's `dqs_o` takes the values 192, 194, …, 318 in turn. `phy_rst_o` pulses exactly once per step, 64 times in all, and during each pulse `dqs_o` shows that step's phase.
- R2: A lane passes at a step when bits [8:0] of its feedback are 16 or more. Feedback bits above bit 8 have no effect.
- R3: With the timer strobe held high, the first reset pulse comes N+1 cycles after the cycle in which start is seen, and each later pulse comes N+3 cycles after the one before. N is WAIT_SHORT when `long_mode_i` is 0 and WAIT_LONG when it is 1. The mode is captured at start.
- R4: The region a lane keeps is its longest run of consecutive passing steps. When two runs are equally long, the one found first is kept.
- R5: A passing run that ends at the last step is joined to a passing run that starts at step 0. The joined region starts where the later run starts. If every step passes, the region starts at 192 and is 128 ticks wide.
- R6: A region's width is 2 ticks per step. A width of 32 or less, or 96 or more, sets `err_o` and stops processing at that lane. That lane and all higher lanes then read 0 on both delay outputs.
- R7: When `x16_i` is 1, each odd lane's start is compared with the raw start of the even lane below it. If the odd start is more than 64 above, 128 is subtracted. If it is more than 64 below, 128 is added.
- R8: When `extra_qclk_i` is 1, 64 is added to every final DQS delay. Within a lane, this addition comes after the pairing step of R7.
- R9: Each lane that finishes without error gets a `dq_o` equal to its final `dqs_o` plus 32.
- R10: After reset, all outputs are 0. `done_o` is high for exactly one cycle at the end of a run. `busy_o` is high from the start until that cycle. A start while `busy_o` is high, including during the `done_o` cycle, is ignored. Outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a sweep when the block is idle |
| long_mode_i | input | 1 | Selects the long settling wait |
| x16_i | input | 1 | Enables odd/even lane pairing |
| extra_qclk_i | input | 1 | Adds a quarter-clock to every DQS result |
| wait_tick_i | input | 1 | Timer strobe; each high cycle counts one wait unit |
| fb_i | input | LANES×FB_W | Feedback count for each lane |
| busy_o | output | 1 | Sweep or finishing in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | A lane failed the width check |
| phy_rst_o | output | 1 | Reset request to the PHY, one per step |
| dqs_o | output | LANES×DLY_W | Per-lane DQS delay (sweep phase, then the result) |
| dq_o | output | LANES×DLY_W | Per-lane DQ delay result |

## Verification
Two events can fall in the same cycle: the end of the run and a new start request. The bench raises `start_i` exactly in the cycle where `done_o` is high. It then checks that `busy_o` stays low, that no further reset pulses appear, and that the results are unchanged. A second collision is a region closed by the wrap merge that is as long as, or longer than, a run already recorded. Feedback patterns are chosen so that the wrapped run wins in one case, an equal-length earlier run wins in another, and the whole sweep passes in a third. The bench compares each lane's delays with values it computes arithmetically.

// File: rtl/wl_pkg.sv
// Shared types for the write-leveling phase sweep engine.
package wl_pkg;
    // Sequencer states: idle, first settle, PHY reset, settle, sample,
    // wrap merge, per-lane finish, done pulse.
    typedef enum logic [2:0] {
        S_IDLE, S_PREW, S_RST, S_WAIT, S_SAMP, S_MERGE, S_FIN, S_DONE
    } wl_state_t;
endpackage

// File: rtl/wl_wait_timer.sv
// Settling timer. A load arms it with the short or long count.
// Every cycle with the strobe high takes one off the count, and
// expired_o is high once the count is zero.
// Assumes both counts are greater than zero.
module wl_wait_timer #(
    parameter int WAIT_SHORT = 1024,
    parameter int WAIT_LONG  = 2048,
    localparam int CNT_W = $clog2(WAIT_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    input  logic tick_i,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt;

    // Load the selected count, or count down on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_i)
            cnt <= long_i ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT);
        else if (tick_i && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);

    // R3
    load_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expired_o);
endmodule

// File: rtl/wl_lane_tracker.sv
// Keeps the run records for one lane: the current passing run, the run
// that began at step 0, and the longest run so far. A strictly longer
// run replaces the longest one, so the earlier of two equal runs stays.
// A merge, issued after the last sample, joins a run that reaches the
// end of the sweep onto the run that began at step 0.
// Assumes FB_W >= 9.
module wl_lane_tracker #(
    parameter int FB_W     = 12,
    parameter int NSTEPS   = 64,
    parameter int PASS_MIN = 16,
    localparam int IDX_W = $clog2(NSTEPS),
    localparam int LEN_W = $clog2(NSTEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             sample_i,
    input  logic             merge_i,
    input  logic [IDX_W-1:0] step_i,
    input  logic [FB_W-1:0]  fb_i,
    output logic [IDX_W-1:0] lg_start_o,
    output logic [LEN_W-1:0] lg_len_o
);
    logic             pass, in_run, init_open;
    logic [IDX_W-1:0] cur_start;
    logic [LEN_W-1:0] cur_len, init_len, wrap_len;

    assign pass     = (fb_i[8:0] >= 9'(PASS_MIN));
    assign wrap_len = init_open ? cur_len : cur_len + init_len;

    // Update the run records on each sample, then apply the wrap merge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            in_run     <= 1'b0;
            init_open  <= 1'b1;
            init_len   <= '0;
            cur_start  <= '0;
            cur_len    <= '0;
            lg_start_o <= '0;
            lg_len_o   <= '0;
        end else if (sample_i) begin
            if (pass) begin
                if (in_run) begin
                    cur_len <= cur_len + 1'b1;
                end else begin
                    cur_start <= step_i;
                    cur_len   <= LEN_W'(1);
                    in_run    <= 1'b1;
                end
                if (init_open)
                    init_len <= init_len + 1'b1;
            end else begin
                in_run    <= 1'b0;
                init_open <= 1'b0;
                if (in_run && cur_len > lg_len_o) begin
                    lg_start_o <= cur_start;
                    lg_len_o   <= cur_len;
                end
            end
        end else if (merge_i && in_run && wrap_len > lg_len_o) begin
            lg_start_o <= cur_start;
            lg_len_o   <= wrap_len;
        end
    end

    // R4
    region_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lg_len_o <= LEN_W'(NSTEPS));
endmodule

// File: rtl/wl_phase_sweep.sv
// Write-leveling phase sweep engine (top). It steps every lane's DQS
// phase through NSTEPS positions. At each position it requests a PHY
// reset, waits the settling time, then samples the lane feedback.
// After the sweep it finishes the lanes one per cycle: width check,
// x16 pairing, optional extra quarter-clock, DQ offset.
// Assumes LANES >= 2 and that the PHY acts on phy_rst_o on its own.
module wl_phase_sweep
    import wl_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FB_W       = 12,
    parameter int DLY_W      = 10,
    parameter int START_TICK = 192,
    parameter int STEP_TICK  = 2,
    parameter int NSTEPS     = 64,
    parameter int MIN_W      = 32,
    parameter int MAX_W      = 96,
    parameter int DQ_OFF     = 32,
    parameter int EXTRA_TICK = 64,
    parameter int PAIR_TH    = 64,
    parameter int PAIR_ADJ   = 128,
    parameter int WAIT_SHORT = 1024,
    parameter int WAIT_LONG  = 2048
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        long_mode_i,
    input  logic                        x16_i,
    input  logic                        extra_qclk_i,
    input  logic                        wait_tick_i,
    input  logic [LANES-1:0][FB_W-1:0]  fb_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        err_o,
    output logic                        phy_rst_o,
    output logic [LANES-1:0][DLY_W-1:0] dqs_o,
    output logic [LANES-1:0][DLY_W-1:0] dq_o
);
    localparam int IDX_W  = $clog2(NSTEPS);
    localparam int LEN_W  = $clog2(NSTEPS + 1);
    localparam int LANE_W = $clog2(LANES);

    wl_state_t                    state;
    logic [IDX_W-1:0]             step;
    logic [LANE_W-1:0]            lane, lane_pair;
    logic                         long_q, x16_q, extra_q, timer_exp;
    logic [LANES-1:0][IDX_W-1:0]  lg_start;
    logic [LANES-1:0][LEN_W-1:0]  lg_len;
    logic [DLY_W-1:0]             reg_tick, ref_tick, wid_tick, pair_tick, fin_dqs;
    logic                         width_bad, accept;

    function automatic logic [DLY_W-1:0] phase_of(input logic [IDX_W:0] idx);
        return DLY_W'(START_TICK) + DLY_W'(idx) * DLY_W'(STEP_TICK);
    endfunction

    assign accept    = (state == S_IDLE) && start_i;
    assign busy_o    = (state != S_IDLE);
    assign done_o    = (state == S_DONE);
    assign phy_rst_o = (state == S_RST);
    assign lane_pair = lane & ~LANE_W'(1);

    wl_wait_timer #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept || state == S_RST),
        .long_i    (accept ? long_mode_i : long_q),
        .tick_i    (wait_tick_i),
        .expired_o (timer_exp)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wl_lane_tracker #(.FB_W(FB_W), .NSTEPS(NSTEPS)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (accept),
            .sample_i   (state == S_SAMP),
            .merge_i    (state == S_MERGE),
            .step_i     (step),
            .fb_i       (fb_i[g]),
            .lg_start_o (lg_start[g]),
            .lg_len_o   (lg_len[g])
        );

        // R9
        dq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && !err_o) |-> dq_o[g] == dqs_o[g] + DLY_W'(DQ_OFF));
    end

    // Final delay of the lane being finished: width check, pairing, extra.
    always_comb begin
        reg_tick  = phase_of({1'b0, lg_start[lane]});
        ref_tick  = phase_of({1'b0, lg_start[lane_pair]});
        wid_tick  = DLY_W'(lg_len[lane]) * DLY_W'(STEP_TICK);
        width_bad = (wid_tick <= DLY_W'(MIN_W)) || (wid_tick >= DLY_W'(MAX_W));
        pair_tick = reg_tick;
        if (x16_q && lane[0]) begin
            if (reg_tick > ref_tick + DLY_W'(PAIR_TH))
                pair_tick = reg_tick - DLY_W'(PAIR_ADJ);
            else if (reg_tick + DLY_W'(PAIR_TH) < ref_tick)
                pair_tick = reg_tick + DLY_W'(PAIR_ADJ);
        end
        fin_dqs = pair_tick + (extra_q ? DLY_W'(EXTRA_TICK) : '0);
    end

    // Sequencer: sweep steps, merge, per-lane finish, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            step    <= '0;
            lane    <= '0;
            long_q  <= 1'b0;
            x16_q   <= 1'b0;
            extra_q <= 1'b0;
            err_o   <= 1'b0;
            dqs_o   <= '0;
            dq_o    <= '0;
        end else begin
            case (state)
                S_IDLE: if (start_i) begin
                    state   <= S_PREW;
                    step    <= '0;
                    long_q  <= long_mode_i;
                    x16_q   <= x16_i;
                    extra_q <= extra_qclk_i;
                    err_o   <= 1'b0;
                    dq_o    <= '0;
                    for (int i = 0; i < LANES; i++) dqs_o[i] <= phase_of('0);
                end
                S_PREW:  if (timer_exp) state <= S_RST;
                S_RST:   state <= S_WAIT;
                S_WAIT:  if (timer_exp) state <= S_SAMP;
                S_SAMP: begin
                    if (step == IDX_W'(NSTEPS - 1)) begin
                        state <= S_MERGE;
                    end else begin
                        state <= S_RST;
                        step  <= step + 1'b1;
                        for (int i = 0; i < LANES; i++)
                            dqs_o[i] <= phase_of({1'b0, step} + 1'b1);
                    end
                end
                S_MERGE: begin
                    state <= S_FIN;
                    lane  <= '0;
                    dqs_o <= '0;
                    dq_o  <= '0;
                end
                S_FIN: begin
                    if (width_bad) begin
                        err_o <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        dqs_o[lane] <= fin_dqs;
                        dq_o[lane]  <= fin_dqs + DLY_W'(DQ_OFF);
                        if (lane == LANE_W'(LANES - 1)) state <= S_DONE;
                        else lane <= lane + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R1
    rst_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_o |-> busy_o && !done_o);
    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(dqs_o) && $stable(dq_o) && $stable(err_o));
    // R6
    err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
endmodule

// File: tb/wl_phase_sweep_test.sv
`timescale 1ns/1ps
module wl_phase_sweep_test;
    localparam int WS = 3, WL = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, lng = 1'b0, x16 = 1'b0, ext = 1'b0, tick = 1'b1;
    logic [3:0][11:0] fb;
    logic busy, done, err, prst;
    logic [3:0][9:0] dqs, dq;
    logic [63:0] pat [4];

    int checks = 0, fails = 0;
    int cyc = 0, s_cyc = 0, last_rst = 0, rst_cnt = 0, done_cnt = 0;
    int sweep_bad = 0, gap_bad = 0, first_gap = 0, exp_gap = 0;
    bit armed = 0;

    always #10 clk = ~clk;

    wl_phase_sweep #(.WAIT_SHORT(WS), .WAIT_LONG(WL)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .long_mode_i(lng),
        .x16_i(x16), .extra_qclk_i(ext), .wait_tick_i(tick), .fb_i(fb),
        .busy_o(busy), .done_o(done), .err_o(err), .phy_rst_o(prst),
        .dqs_o(dqs), .dq_o(dq));

    // Feedback model (R2): pass = 0xE10 (low 9 bits 16), fail = 0xE0F (15).
    always_comb begin
        for (int l = 0; l < 4; l++) begin
            if (dqs[l] >= 10'd192 && dqs[l] <= 10'd318)
                fb[l] = pat[l][(dqs[l] - 10'd192) >> 1] ? 12'hE10 : 12'hE0F;
            else
                fb[l] = 12'hE0F;
        end
    end

    // Monitor: reset pulse spacing, sweep phase and done count.
    always @(negedge clk) begin
        cyc++;
        if (armed && start) begin s_cyc = cyc; armed = 0; end
        if (prst) begin
            if (rst_cnt == 0) first_gap = cyc - s_cyc;
            else if (cyc - last_rst != exp_gap) gap_bad++;
            if (dqs[0] != 10'(192 + 2 * rst_cnt)) sweep_bad++;
            rst_cnt++;
            last_rst = cyc;
        end
        if (done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] run_mask(input int s, input int n);
        logic [63:0] m = '0;
        for (int i = 0; i < n; i++) m[(s + i) % 64] = 1'b1;
        return m;
    endfunction

    // Longest run, earlier one on ties, with wrap join (R4, R5).
    task automatic ref_region(input logic [63:0] m, output int st, output int len);
        int init = 0, i = 0, s, l;
        st = 0; len = 0;
        if (&m) begin len = 64; return; end
        while (init < 64 && m[init]) init++;
        while (i < 64) begin
            if (m[i]) begin
                s = i; l = 0;
                while (i < 64 && m[i]) begin l++; i++; end
                if (s + l == 64) l += init;
                if (l > len) begin len = l; st = s; end
            end else i++;
        end
    endtask

    task automatic run_case(input logic [63:0] p0, p1, p2, p3,
                            input bit lm, xm, em, mid_start, done_start);
        int st[4], ln[4], edqs[4], edq[4], t, r, hold_q;
        bit failed = 0;
        pat[0] = p0; pat[1] = p1; pat[2] = p2; pat[3] = p3;
        for (int l = 0; l < 4; l++) begin
            ref_region(pat[l], st[l], ln[l]);
            edqs[l] = 0; edq[l] = 0;
            if (!failed) begin
                if (2 * ln[l] <= 32 || 2 * ln[l] >= 96) failed = 1;
                else begin
                    t = 192 + 2 * st[l];
                    if (xm && l % 2 == 1) begin
                        r = 192 + 2 * st[l - 1];
                        if (t > r + 64) t -= 128;
                        else if (t + 64 < r) t += 128;
                    end
                    if (em) t += 64;
                    edqs[l] = t; edq[l] = t + 32;
                end
            end
        end
        @(negedge clk);
        rst_cnt = 0; done_cnt = 0; sweep_bad = 0; gap_bad = 0; armed = 1;
        exp_gap = (lm ? WL : WS) + 3;
        #2; lng = lm; x16 = xm; ext = em; start = 1'b1;
        @(negedge clk); #2; start = 1'b0; lng = ~lm; x16 = ~xm; ext = ~em;
        if (mid_start) begin
            repeat (100) @(negedge clk);
            #2; start = 1'b1; @(negedge clk); #2; start = 1'b0;
        end
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done, "R10 done seen", done, 1);
        if (done_start) begin
            #2; start = 1'b1; @(negedge clk); #2; start = 1'b0;
            chk(!busy, "R10 start in done cycle ignored", busy, 0);
        end
        hold_q = dqs[0];
        repeat (12) @(negedge clk);
        chk(done_cnt == 1, "R10 done width", done_cnt, 1);
        chk(!busy && dqs[0] == hold_q, "R10 hold", dqs[0], hold_q);
        chk(rst_cnt == 64 && sweep_bad == 0, "R1 sweep steps", rst_cnt, 64);
        chk(first_gap == exp_gap - 2, "R3 first wait", first_gap, exp_gap - 2);
        chk(gap_bad == 0, "R3 step wait", gap_bad, 0);
        chk(err == failed, "R6 error flag", err, failed);
        for (int l = 0; l < 4; l++) begin
            chk(dqs[l] == 10'(edqs[l]), "R4/R5/R7/R8 dqs lane", dqs[l], edqs[l]);
            chk(dq[l] == 10'(edq[l]), "R9 dq lane", dq[l], edq[l]);
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int l = 0; l < 4; l++) pat[l] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !prst && dqs == '0 && dq == '0,
            "R10 reset state", busy, 0);
        rst_n = 1'b1;
        // R4 tie (lane1), R5 wrap beats a run (lane2), 34-tick boundary (lane3)
        run_case(run_mask(10, 30), run_mask(5, 20) | run_mask(40, 20),
                 run_mask(54, 24) | run_mask(20, 20), run_mask(30, 17), 0, 0, 0, 0, 0);
        // R7 pairing both ways, R8 extra, R3 long wait, busy start ignored
        run_case(run_mask(0, 20), run_mask(40, 20), run_mask(40, 24), run_mask(0, 20),
                 1, 1, 1, 1, 0);
        // R6 stop at lane 1 (32 ticks), 94-tick pass, start in done cycle
        run_case(run_mask(2, 47), run_mask(0, 16), run_mask(10, 30), run_mask(0, 48),
                 0, 0, 0, 0, 1);
        // R5 all pass gives 128 ticks -> R6 error at lane 0
        run_case('1, run_mask(5, 30), run_mask(5, 30), run_mask(5, 30), 0, 0, 0, 0, 0);
        // R6 upper boundary 96 ticks on lane 2, x16 no adjustment
        run_case(run_mask(8, 30), run_mask(20, 30), run_mask(0, 48), run_mask(0, 30),
                 0, 1, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule